// File: doc/BRIEF.md
# Transmit Interrupt Status and Request Line

This block turns the transmit path's FIFO status into interrupt status for an audio serial interface. It builds a raw status word from three sources: a sticky underrun flag, a transmit-request bit that follows the FIFO half-empty flag, and a transmit-done bit that is set while the FIFO is empty and the transmitter is idle. The raw word is masked bit by bit with an enable word. A registered, level-sensitive interrupt line is high while any enabled source is active.

The underrun flag is set when a drain leaves the FIFO empty. It is cleared by a push that leaves the FIFO non-empty, or by a write to the clear register with the underrun-clear bit set. When a set and a clear arrive in the same cycle, the set wins. A narrow read view gives the low bits of the raw word so that software can poll all sources with one read.

Top module: `tx_irq_status`

## Requirements
- R1: After reset, `raw_o`, `masked_o`, `all_ints_o` and `irq_o` are all zero until the first status update.
- R2: Raw bit 0 (underrun) reflects the sticky underrun flag. The flag keeps its value in any cycle without a set or clear event, and the new value is visible one cycle after the event.
- R3: Raw bit 1 (transmit request) equals `fifo_half_i` as sampled at the previous clock edge.
- R4: Raw bit 2 (transmit done) is 1 exactly when `fifo_empty_i` was 1 and `tx_busy_i` was 0 at the previous clock edge.
- R5: A `drain_empty_i` pulse sets the underrun flag, and a `push_fill_i` pulse clears it.
- R6: A cycle with `clr_wr_i`=1 and `clr_data_i[3]`=1 clears the underrun flag. A clear write with bit 3 at 0, or any `clr_data_i` value while `clr_wr_i`=0, leaves the flag unchanged.
- R7: When `drain_empty_i` coincides with a push or with a clear write, the underrun flag ends up set.
- R8: `masked_o` equals `raw_o & int_en_i`. `irq_o` is registered and equals the OR of `raw_o & int_en_i`, using the enable value from the previous cycle.
- R9: Raw bits 3 and above always read 0, and `all_ints_o` equals raw bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_half_i | input | 1 | Transmit FIFO is at or below half full |
| tx_busy_i | input | 1 | Transmitter is shifting data |
| drain_empty_i | input | 1 | Pulse: a drain left the FIFO empty |
| push_fill_i | input | 1 | Pulse: a push left the FIFO non-empty |
| int_en_i | input | 8 | Per-bit interrupt enable |
| clr_wr_i | input | 1 | Clear-register write strobe |
| clr_data_i | input | 8 | Clear-register write data; bit 3 clears underrun |
| raw_o | output | 8 | Raw interrupt status |
| masked_o | output | 8 | Raw status AND enable |
| all_ints_o | output | 7 | Combined raw view, low 7 bits |
| irq_o | output | 1 | Level interrupt request |

## Verification
Random level inputs for empty, half-empty and busy check the two level-following bits. The busy/empty combinations separate the transmit-done AND term from either input alone. Sparse random set, push and clear pulses, including clear writes with bit 3 both high and low, exercise the sticky flag against a reference model. Directed cycles set the flag and then apply each clear source alone and together with a set, which separates clear-only, no-effect and set-priority behaviour. Changing enable words show whether the interrupt line follows the masked sources with the one-cycle register delay.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;
  localparam int RAW_W      = 8;
  localparam int VIEW_W     = 7;
  localparam int CLR_W      = 8;
  localparam int IDX_URUN   = 0;
  localparam int IDX_TXREQ  = 1;
  localparam int IDX_TXDONE = 2;
  localparam int CLR_UR_BIT = 3;

  typedef enum logic [1:0] {
    SRC_URUN   = 2'd0,
    SRC_TXREQ  = 2'd1,
    SRC_TXDONE = 2'd2,
    SRC_NONE   = 2'd3
  } src_e;

  function automatic src_e src_of(input int idx);
    case (idx)
      IDX_URUN:   return SRC_URUN;
      IDX_TXREQ:  return SRC_TXREQ;
      IDX_TXDONE: return SRC_TXDONE;
      default:    return SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tx_irq_urun_flag.sv
module tx_irq_urun_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic push_clr_i,
  input  logic wr_clr_i,
  output logic flag_d_o,
  output logic flag_q_o
);
  logic flag_d;
  logic flag_q;
  logic flag_en;

  always_comb begin
    flag_d  = flag_q;
    flag_en = set_i | push_clr_i | wr_clr_i;
    if (set_i)                        flag_d = 1'b1;
    else if (push_clr_i || wr_clr_i)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_d_o = flag_d;
  assign flag_q_o = flag_q;
endmodule

// File: rtl/tx_irq_raw_build.sv
module tx_irq_raw_build
  import tx_irq_pkg::*;
#(
  parameter int W = RAW_W
) (
  input  logic         urun_i,
  input  logic         half_i,
  input  logic         empty_i,
  input  logic         busy_i,
  output logic [W-1:0] raw_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam src_e SRC = src_of(g);
    if (SRC == SRC_URUN) begin : g_ur
      assign raw_o[g] = urun_i;
    end else if (SRC == SRC_TXREQ) begin : g_rq
      assign raw_o[g] = half_i;
    end else if (SRC == SRC_TXDONE) begin : g_dn
      assign raw_o[g] = empty_i & ~busy_i;
    end else begin : g_zero
      assign raw_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tx_irq_out_reg.sv
module tx_irq_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_d_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] raw_q_o,
  output logic         irq_q_o
);
  logic [W-1:0] raw_q;
  logic         irq_d;
  logic         irq_q;

  always_comb irq_d = |(raw_d_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d_i;
      irq_q <= irq_d;
    end
  end

  assign raw_q_o = raw_q;
  assign irq_q_o = irq_q;
endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status
  import tx_irq_pkg::*;
#(
  parameter int RW = RAW_W,
  parameter int VW = VIEW_W,
  parameter int CW = CLR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty_i,
  input  logic          fifo_half_i,
  input  logic          tx_busy_i,
  input  logic          drain_empty_i,
  input  logic          push_fill_i,
  input  logic [RW-1:0] int_en_i,
  input  logic          clr_wr_i,
  input  logic [CW-1:0] clr_data_i,
  output logic [RW-1:0] raw_o,
  output logic [RW-1:0] masked_o,
  output logic [VW-1:0] all_ints_o,
  output logic          irq_o
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          wr_clr;
  logic          flag_d;
  logic          flag_q;
  logic [RW-1:0] raw_d;
  logic [RW-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign wr_clr = clr_wr_i & clr_data_i[CLR_UR_BIT];

  tx_irq_urun_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_i      (drain_empty_i),
    .push_clr_i (push_fill_i),
    .wr_clr_i   (wr_clr),
    .flag_d_o   (flag_d),
    .flag_q_o   (flag_q)
  );

  tx_irq_raw_build #(.W(RW)) u_build (
    .urun_i  (flag_d),
    .half_i  (fifo_half_i),
    .empty_i (fifo_empty_i),
    .busy_i  (tx_busy_i),
    .raw_o   (raw_d)
  );

  tx_irq_out_reg #(.W(RW)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .raw_d_i (raw_d),
    .en_i    (int_en_i),
    .raw_q_o (raw_q),
    .irq_q_o (irq_o)
  );

  assign raw_o      = raw_q;
  assign masked_o   = raw_q & int_en_i;
  assign all_ints_o = raw_q[VW-1:0];

  logic unused_ok;
  assign unused_ok = flag_q;
endmodule

// File: rtl/tx_irq_status_chk.sv
module tx_irq_status_chk
  import tx_irq_pkg::*;
#(
  parameter int RW = RAW_W,
  parameter int CW = CLR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_empty_i,
  input logic          fifo_half_i,
  input logic          tx_busy_i,
  input logic          drain_empty_i,
  input logic          push_fill_i,
  input logic [RW-1:0] int_en_i,
  input logic          clr_wr_i,
  input logic [CW-1:0] clr_data_i,
  input logic [RW-1:0] raw_o,
  input logic          irq_o
);
  p_ur_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_empty_i |=> raw_o[IDX_URUN]);

  p_ur_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_empty_i && (push_fill_i || clr_wr_i)) |=> raw_o[IDX_URUN]);

  p_ur_wrclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_empty_i && clr_wr_i && clr_data_i[CLR_UR_BIT]) |=> !raw_o[IDX_URUN]);

  p_ur_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_empty_i && push_fill_i) |=> !raw_o[IDX_URUN]);

  p_ur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_empty_i && !push_fill_i && !(clr_wr_i && clr_data_i[CLR_UR_BIT]))
      |=> (raw_o[IDX_URUN] == $past(raw_o[IDX_URUN])));

  p_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_o[IDX_TXREQ] == $past(fifo_half_i)));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_o[IDX_TXDONE] == ($past(fifo_empty_i) && !$past(tx_busy_i))));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |(raw_o & $past(int_en_i))));

  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o[RW-1:IDX_TXDONE+1] == '0);
endmodule

bind tx_irq_status tx_irq_status_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .fifo_empty_i  (fifo_empty_i),
  .fifo_half_i   (fifo_half_i),
  .tx_busy_i     (tx_busy_i),
  .drain_empty_i (drain_empty_i),
  .push_fill_i   (push_fill_i),
  .int_en_i      (int_en_i),
  .clr_wr_i      (clr_wr_i),
  .clr_data_i    (clr_data_i),
  .raw_o         (raw_o),
  .irq_o         (irq_o)
);

// File: tb/tx_irq_status_tb.sv
module tx_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_empty_i, fifo_half_i, tx_busy_i;
  logic       drain_empty_i, push_fill_i, clr_wr_i;
  logic [7:0] int_en_i, clr_data_i;
  logic [7:0] raw_o, masked_o;
  logic [6:0] all_ints_o;
  logic       irq_o;

  int tests_run = 0;
  int tests_fail = 0;
  bit done = 1'b0;

  logic       m_flag;
  logic [7:0] exp_raw;
  logic       exp_irq;

  always #2.5 clk = ~clk;

  tx_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i), .fifo_half_i(fifo_half_i),
    .tx_busy_i(tx_busy_i), .drain_empty_i(drain_empty_i), .push_fill_i(push_fill_i),
    .int_en_i(int_en_i), .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
    .raw_o(raw_o), .masked_o(masked_o), .all_ints_o(all_ints_o), .irq_o(irq_o)
  );

  function automatic logic next_flag(input logic f, input logic s, input logic p,
                                     input logic w, input logic [7:0] d);
    if (s) return 1'b1;
    if (p || (w && d[3])) return 1'b0;
    return f;
  endfunction

  function automatic logic [7:0] make_raw(input logic f, input logic h,
                                          input logic e, input logic b);
    return {5'b0, e & ~b, h, f};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string ur_tag);
    chk(ur_tag, 32'(raw_o[0]), 32'(exp_raw[0]));
    chk("R3 txreq bit", 32'(raw_o[1]), 32'(exp_raw[1]));
    chk("R4 txdone bit", 32'(raw_o[2]), 32'(exp_raw[2]));
    chk("R9 unused bits", 32'(raw_o[7:3]), 32'(0));
    chk("R9 view", 32'(all_ints_o), 32'(exp_raw[6:0]));
    chk("R8 masked", 32'(masked_o), 32'(exp_raw & int_en_i));
    chk("R8 irq", 32'(irq_o), 32'(exp_irq));
  endtask

  task automatic drive(input logic e, input logic h, input logic b, input logic s,
                       input logic p, input logic w, input logic [7:0] d, input logic [7:0] en);
    fifo_empty_i = e; fifo_half_i = h; tx_busy_i = b; drain_empty_i = s;
    push_fill_i = p; clr_wr_i = w; clr_data_i = d; int_en_i = en;
    m_flag  = next_flag(m_flag, s, p, w, d);
    exp_raw = make_raw(m_flag, h, e, b);
    exp_irq = |(exp_raw & en);
  endtask

  task automatic step(input string ur_tag, input logic e, input logic h, input logic b,
                      input logic s, input logic p, input logic w, input logic [7:0] d,
                      input logic [7:0] en);
    drive(e, h, b, s, p, w, d, en);
    @(negedge clk);
    check_outputs(ur_tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    m_flag = 1'b0;
    fifo_empty_i = 0; fifo_half_i = 0; tx_busy_i = 0; drain_empty_i = 0;
    push_fill_i = 0; clr_wr_i = 0; clr_data_i = 0; int_en_i = 8'hff;
    exp_raw = '0; exp_irq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset raw", 32'(raw_o), 0);
    chk("R1 reset view", 32'(all_ints_o), 0);
    chk("R1 reset masked", 32'(masked_o), 0);
    chk("R1 reset irq", 32'(irq_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle raw", 32'(raw_o), 0);
    chk("R1 idle irq", 32'(irq_o), 0);

    // directed
    step("R5 drain sets", 1, 0, 0, 1, 0, 0, 8'h00, 8'h01);
    step("R2 flag holds", 1, 0, 1, 0, 0, 0, 8'h00, 8'h01);
    step("R6 clear without bit3 ignored", 0, 1, 0, 0, 0, 1, 8'hf7, 8'h01);
    step("R6 data without strobe ignored", 0, 1, 0, 0, 0, 0, 8'h08, 8'h00);
    step("R6 clear bit3 clears", 0, 0, 0, 0, 0, 1, 8'h08, 8'h01);
    step("R7 drain wins over clear", 1, 0, 0, 1, 0, 1, 8'h08, 8'h04);
    step("R5 push clears", 0, 1, 1, 0, 1, 0, 8'h00, 8'h02);
    step("R7 drain wins over push", 1, 1, 0, 1, 1, 0, 8'h00, 8'h00);
    step("R2 flag holds", 1, 1, 0, 0, 0, 0, 8'h00, 8'h04);
    step("R4 busy blocks done", 1, 0, 1, 0, 1, 0, 8'h00, 8'h04);

    // random
    for (int i = 0; i < 3000; i++) begin
      logic s, p, w;
      logic [7:0] d, en;
      s  = ($urandom_range(0, 7) == 0);
      p  = ($urandom_range(0, 5) == 0);
      w  = ($urandom_range(0, 6) == 0);
      d  = 8'($urandom);
      en = (i % 16 == 0) ? 8'($urandom) : int_en_i;
      step("R2 R5 random underrun", 1'($urandom), 1'($urandom), 1'($urandom),
           s, p, w, d, en);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end
endmodule